// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects five interrupt requests for a small control core and tells the core which handler to enter. The five requests are:

- two active-low external request pins;
- two timer overflow flags;
- one serial request, formed from a receive flag and a transmit flag that share a vector.

Software programs the block through three sets of inputs:

- one enable bit per source, and a global enable that gates all of them;
- one priority bit per source, which places the source in the high or the low level;
- one type bit per external pin, which picks whether that request latches on a falling edge or follows the pin level.

The controller presents a single request with the handler address of the winning source. The core answers with an acknowledge strobe. On acknowledge the controller records which level is now in service and clears the flag that the hardware owns. A return strobe from the core ends the most recent service level.

A low-level handler can be preempted by a high-level request. While a high-level handler runs, no request is presented. Within one level, ties are broken by a fixed polling order.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, no request is presented, all four hardware flags (`flag_o`) read 0 while the pins are high, and `svc_o` is 2'b00.
- R2: While `en_all_i` is 0, `irq_req_o` stays 0 whatever flags, enables and priorities are set.
- R3: A source competes only when its bit in `en_src_i` is 1. The bit order is: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. `pri_reg_i` uses the same bit order.
- R4: The presented address is 16'h0003 + 8 × index, where index is the bit position in R3. This gives 0003h, 000Bh, 0013h, 001Bh and 0023h.
- R5: Among competing sources of the same level, the lowest index wins.
- R6: A source whose `pri_reg_i` bit is 1 beats every source whose bit is 0, whatever their indices.
- R7: In edge mode (`ext_edge_i` bit = 1), an external flag sets on the first clock edge at which the pin reads 0 after reading 1 at the previous edge. The flag stays set after the pin returns high, and it is cleared by the acknowledge of that source.
- R8: In level mode (`ext_edge_i` bit = 0), an external flag equals the inverted pin, one clock later. An acknowledge does not clear it.
- R9: A timer flag sets on a `tmr_ovf_i` pulse and clears on acknowledge of that timer. The serial request follows the OR of `ser_rx_i` and `ser_tx_i`, and an acknowledge does not remove it.
- R10: An acknowledge while a request is presented marks its level in service: `svc_o[1]` is the high level, `svc_o[0]` the low level. While the low level is in service only high-level requests are presented. While the high level is in service none are presented.
- R11: A `reti_i` strobe clears `svc_o[1]` when it is set, and otherwise clears `svc_o[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_n_i | input | 2 | External request pins, active low (bit 0 = external 0) |
| ext_edge_i | input | 2 | Per-pin type: 1 edge, 0 level |
| tmr_ovf_i | input | 2 | Timer overflow set pulses (bit 0 = timer 0) |
| ser_rx_i | input | 1 | Serial receive flag |
| ser_tx_i | input | 1 | Serial transmit flag |
| en_all_i | input | 1 | Global enable |
| en_src_i | input | 5 | Per-source enables, order as R3 |
| pri_reg_i | input | 5 | Per-source level, 1 = high |
| irq_ack_i | input | 1 | Core acknowledges the presented request |
| reti_i | input | 1 | Core returns from a handler |
| irq_req_o | output | 1 | A request is presented |
| irq_vec_o | output | 16 | Handler address of the winner |
| flag_o | output | 4 | Flags {timer 1, external 1, timer 0, external 0} |
| svc_o | output | 2 | In-service levels {high, low} |

## Verification
The assertions assume that the core behaves as a core would:
- `irq_ack_i` is raised only in a cycle where `irq_req_o` is high;
- `reti_i` never coincides with an acknowledge;
- `reti_i` is sent only while some level is in service.

The stimulus keeps to this. It raises acknowledge only after it has checked that the request is present. It pulses return in its own cycles, and it never issues more returns than acknowledges. The large sweep over all enable and priority patterns holds every flag pending and never acknowledges. This keeps the in-service state idle, so every arbitration outcome is reached without disturbing the protocol.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned NSRC  = 5;
    localparam int unsigned NPAIR = 2;
    localparam int unsigned IDX_W = $clog2(NSRC);

    typedef struct packed {
        logic hi;
        logic lo;
    } svc_t;

    typedef struct packed {
        logic pin;
        logic flag;
    } ext_st_t;
endpackage

// File: rtl/irqc_ext_latch.sv
module irqc_ext_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic flag
);
    import irqc_pkg::*;

    ext_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pin = pin_n;
        if (edge_mode) begin
            if (st_q.pin && !pin_n) begin
                st_d.flag = 1'b1;
            end else if (clr) begin
                st_d.flag = 1'b0;
            end
        end else begin
            st_d.flag = !pin_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pin: 1'b1, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/irqc_sticky.sv
module irqc_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set) begin
            flag_d = 1'b1;
        end else if (clr) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int unsigned N = 5,
    localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         valid,
    output logic [W-1:0] idx
);
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
    parameter int unsigned VEC_W    = 16,
    parameter int unsigned VEC_BASE = 3,
    parameter int unsigned VEC_STEP = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  ext_n_i,
    input  logic [1:0]                  ext_edge_i,
    input  logic [1:0]                  tmr_ovf_i,
    input  logic                        ser_rx_i,
    input  logic                        ser_tx_i,
    input  logic                        en_all_i,
    input  logic [4:0]                  en_src_i,
    input  logic [4:0]                  pri_reg_i,
    input  logic                        irq_ack_i,
    input  logic                        reti_i,
    output logic                        irq_req_o,
    output logic [VEC_W-1:0]            irq_vec_o,
    output logic [3:0]                  flag_o,
    output logic [1:0]                  svc_o
);
    import irqc_pkg::*;

    logic [NSRC-1:0]  src_raw;
    logic [NSRC-1:0]  armed;
    logic [NSRC-1:0]  hi_req;
    logic [NSRC-1:0]  lo_req;
    logic [NSRC-1:0]  clr_vec;
    logic [NPAIR-1:0] ext_flag;
    logic [NPAIR-1:0] tmr_flag;
    logic             hi_v, lo_v, take_hi, take_lo, fire;
    logic [IDX_W-1:0] hi_idx, lo_idx, win_idx;
    svc_t             svc_d, svc_q;

    // External k sits at index 2k, timer k at index 2k+1.
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        irqc_ext_latch u_ext (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n_i[k]),
            .edge_mode (ext_edge_i[k]),
            .clr       (clr_vec[2*k]),
            .flag      (ext_flag[k])
        );
        irqc_sticky u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (tmr_ovf_i[k]),
            .clr   (clr_vec[2*k+1]),
            .flag  (tmr_flag[k])
        );
        assign src_raw[2*k]   = ext_flag[k];
        assign src_raw[2*k+1] = tmr_flag[k];
    end
    assign src_raw[NSRC-1] = ser_rx_i | ser_tx_i;

    assign armed  = src_raw & en_src_i & {NSRC{en_all_i}};
    assign hi_req = armed & pri_reg_i;
    assign lo_req = armed & ~pri_reg_i;

    irqc_pick #(.N(NSRC)) u_pick_hi (.req(hi_req), .valid(hi_v), .idx(hi_idx));
    irqc_pick #(.N(NSRC)) u_pick_lo (.req(lo_req), .valid(lo_v), .idx(lo_idx));

    always_comb begin
        take_hi = hi_v && !svc_q.hi;
        take_lo = !take_hi && lo_v && !svc_q.hi && !svc_q.lo;
        win_idx = take_hi ? hi_idx : lo_idx;
        fire    = irq_ack_i && (take_hi || take_lo);
        clr_vec = '0;
        if (fire) begin
            clr_vec[win_idx] = 1'b1;
        end
        svc_d = svc_q;
        if (fire) begin
            if (take_hi) begin
                svc_d.hi = 1'b1;
            end else begin
                svc_d.lo = 1'b1;
            end
        end else if (reti_i) begin
            if (svc_q.hi) begin
                svc_d.hi = 1'b0;
            end else begin
                svc_d.lo = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q <= '0;
        end else begin
            svc_q <= svc_d;
        end
    end

    assign irq_req_o = take_hi || take_lo;
    assign irq_vec_o = VEC_W'(VEC_BASE + int'(win_idx) * VEC_STEP);
    assign flag_o    = {tmr_flag[1], ext_flag[1], tmr_flag[0], ext_flag[0]};
    assign svc_o     = {svc_q.hi, svc_q.lo};
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
    parameter int unsigned VEC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       ext_n_i,
    input logic [1:0]       ext_edge_i,
    input logic [1:0]       tmr_ovf_i,
    input logic             en_all_i,
    input logic             irq_ack_i,
    input logic             reti_i,
    input logic             irq_req_o,
    input logic [VEC_W-1:0] irq_vec_o,
    input logic [3:0]       flag_o,
    input logic [1:0]       svc_o
);
    p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_all_i |-> !irq_req_o);

    p_vec_grid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (irq_vec_o[2:0] == 3'd3 && irq_vec_o <= VEC_W'(16'h0023)));

    p_edge_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_edge_i[0] && $past(ext_n_i[0]) && !ext_n_i[0]) |=> flag_o[0]);

    p_timer_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && irq_req_o && irq_vec_o == VEC_W'(16'h000B) && !tmr_ovf_i[0])
        |=> !flag_o[1]);

    p_hi_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        svc_o[1] |-> !irq_req_o);

    p_ack_marks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && irq_req_o) |=> (svc_o != 2'b00));

    p_reti_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !irq_ack_i && svc_o[1]) |=> (!svc_o[1] && svc_o[0] == $past(svc_o[0])));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  ext_n_i, ext_edge_i, tmr_ovf_i;
    logic        ser_rx_i, ser_tx_i, en_all_i;
    logic [4:0]  en_src_i, pri_reg_i;
    logic        irq_ack_i, reti_i;
    logic        irq_req_o;
    logic [15:0] irq_vec_o;
    logic [3:0]  flag_o;
    logic [1:0]  svc_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_vec_ctrl u_dut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int low_idx(input logic [4:0] m);
        for (int i = 0; i < 5; i++) begin
            if (m[i]) return i;
        end
        return -1;
    endfunction

    task automatic ack_once();
        irq_ack_i = 1'b1;
        tick();
        irq_ack_i = 1'b0;
    endtask

    task automatic reti_once();
        reti_i = 1'b1;
        tick();
        reti_i = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ext_n_i = 2'b11; ext_edge_i = 2'b00; tmr_ovf_i = 2'b00;
        ser_rx_i = 1'b0; ser_tx_i = 1'b0; en_all_i = 1'b0; en_src_i = '0;
        pri_reg_i = '0; irq_ack_i = 1'b0; reti_i = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(irq_req_o == 1'b0, "R1 req", irq_req_o, 0);
        chk(flag_o == 4'h0, "R1 flags", flag_o, 0);
        chk(svc_o == 2'b00, "R1 svc", svc_o, 0);

        // Hold all five requests pending.
        ext_n_i = 2'b00; tmr_ovf_i = 2'b11; ser_rx_i = 1'b1;
        tick();
        tmr_ovf_i = 2'b00;
        tick();
        chk(flag_o == 4'hF, "R8/R9 all flags set", flag_o, 4'hF);

        // R3/R4/R5/R6 sweep over every enable and priority pattern.
        en_all_i = 1'b1;
        for (int e = 0; e < 32; e++) begin
            for (int p = 0; p < 32; p++) begin
                logic [4:0] em, pm;
                int w;
                em = e[4:0]; pm = p[4:0];
                en_src_i = em; pri_reg_i = pm;
                #0.2;
                w = low_idx(em & pm);
                if (w < 0) w = low_idx(em & ~pm);
                chk(irq_req_o == (w >= 0), "R3 req present", irq_req_o, (w >= 0));
                if (w >= 0) begin
                    chk(irq_vec_o == 16'(3 + 8 * w), "R4/R5/R6 vector", irq_vec_o, 16'(3 + 8 * w));
                end
            end
        end
        // R2 global mask.
        en_all_i = 1'b0;
        for (int e = 0; e < 32; e++) begin
            logic [4:0] em;
            em = e[4:0];
            en_src_i = em; pri_reg_i = ~em;
            #0.2;
            chk(irq_req_o == 1'b0, "R2 global mask", irq_req_o, 0);
        end

        // Drop level requests; R8 flags follow pins.
        en_all_i = 1'b1; en_src_i = 5'h1F; pri_reg_i = 5'h00;
        ser_rx_i = 1'b0; ext_n_i = 2'b11;
        tick();
        chk(flag_o[0] == 1'b0 && flag_o[2] == 1'b0, "R8 level release", flag_o, 4'hA);

        // R9: timer 0 acknowledged and cleared.
        chk(irq_vec_o == 16'h000B, "R9 timer0 vector", irq_vec_o, 16'h000B);
        ack_once();
        chk(flag_o[1] == 1'b0, "R9 timer0 cleared", flag_o[1], 0);
        chk(svc_o == 2'b01, "R10 low in service", svc_o, 1);
        chk(irq_req_o == 1'b0, "R10 low blocks low", irq_req_o, 0);

        // R10: high request preempts low.
        pri_reg_i = 5'b01000;
        #0.2;
        chk(irq_req_o == 1'b1 && irq_vec_o == 16'h001B, "R10 preempt", irq_vec_o, 16'h001B);
        ack_once();
        chk(svc_o == 2'b11, "R10 both in service", svc_o, 3);
        chk(flag_o[3] == 1'b0, "R9 timer1 cleared", flag_o[3], 0);
        pri_reg_i = 5'b01010; tmr_ovf_i = 2'b01;
        tick();
        tmr_ovf_i = 2'b00;
        chk(irq_req_o == 1'b0, "R10 high blocks all", irq_req_o, 0);

        // R11 return ordering.
        reti_once();
        chk(svc_o == 2'b01, "R11 high released first", svc_o, 1);
        chk(irq_req_o == 1'b1 && irq_vec_o == 16'h000B, "R10 high over low", irq_vec_o, 16'h000B);
        ack_once();
        chk(svc_o == 2'b11, "R10 re-entered high", svc_o, 3);
        reti_once();
        reti_once();
        chk(svc_o == 2'b00, "R11 low released", svc_o, 0);

        // R7 edge mode on external 0.
        pri_reg_i = 5'h00; en_src_i = 5'b00001; ext_edge_i = 2'b01;
        tick();
        chk(flag_o[0] == 1'b0, "R7 no flag while high", flag_o[0], 0);
        ext_n_i[0] = 1'b0;
        tick();
        chk(flag_o[0] == 1'b1, "R7 falling edge latched", flag_o[0], 1);
        ext_n_i[0] = 1'b1;
        tick();
        chk(flag_o[0] == 1'b1, "R7 held after release", flag_o[0], 1);
        chk(irq_vec_o == 16'h0003 && irq_req_o, "R7 vector", irq_vec_o, 16'h0003);
        ack_once();
        chk(flag_o[0] == 1'b0, "R7 cleared by ack", flag_o[0], 0);
        reti_once();

        // R8 level mode on external 1: ack does not clear.
        en_src_i = 5'b00100; ext_n_i[1] = 1'b0;
        tick();
        chk(flag_o[2] == 1'b1, "R8 level set", flag_o[2], 1);
        ack_once();
        chk(flag_o[2] == 1'b1, "R8 not cleared by ack", flag_o[2], 1);
        reti_once();
        ext_n_i[1] = 1'b1;
        tick();
        chk(flag_o[2] == 1'b0, "R8 follows pin", flag_o[2], 0);

        // R9 serial request survives acknowledge.
        en_src_i = 5'b10000; ser_tx_i = 1'b1;
        #0.2;
        chk(irq_req_o && irq_vec_o == 16'h0023, "R9 serial vector", irq_vec_o, 16'h0023);
        ack_once();
        reti_once();
        chk(irq_req_o && irq_vec_o == 16'h0023, "R9 serial persists", irq_vec_o, 16'h0023);
        ser_tx_i = 1'b0;
        tick();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule